// File: doc/BRIEF.md
# Serial Port Transmit/Receive Queue Pair with Level Interrupts

This block holds the two data queues of a serial peripheral controller and the interrupt logic that watches them. The transmit queue is filled by a register-write port and drained word by word by the serial shifter. The receive queue is filled by the shifter and drained by a register-read port. Each queue stores one right-justified data frame per entry. Its width and depth are parameters, with defaults of 16 bits and 256 entries.

Two level interrupts follow the queue fill counts on every cycle, and each has its own programmable level. The transmit one says the queue is nearly drained. The receive one says the queue is nearly full. Three sticky error flags record misuse: a write to a full transmit queue, a shifter push into a full receive queue, and a read from an empty receive queue. All five sources appear in a raw status vector and in a masked status vector, and the masked vector is ORed into one active-high interrupt line. Clearing the enable input empties both queues at once.

Top module: `spi_fifo_irq_core`

## Requirements
- R1: After reset both fill levels read 0 and `irq_raw` reads 5'b00001. Only the transmit low-level source is active at that point.
- R2: The transmit queue returns words in write order on `tx_data` and counts up to DEPTH entries on `tx_level`. `tx_empty` is high exactly when `tx_level` is 0, and a pop on an empty transmit queue has no effect.
- R3: `irq_raw[0]` (transmit low level) is high while `tx_level` is less than or equal to `tx_thresh`.
- R4: `irq_raw[4]` (receive high level) is high while `rx_level` is greater than or equal to `rx_thresh` + 1.
- R5: A write to a full transmit queue is dropped and leaves the stored words unchanged. On the next cycle it sets the sticky flag `irq_raw[1]`.
- R6: A shifter push into a full receive queue is discarded. On the next cycle it sets the sticky flag `irq_raw[2]`.
- R7: A read of an empty receive queue leaves `rx_level` at 0 and sets the sticky flag `irq_raw[3]` on the next cycle. The value on `rd_data` is not valid for that read.
- R8: Bits 1 to 3 of `irq_raw` stay set until a cycle with `err_clr` high, which clears all three. A new error event in the same cycle as the clear wins, and its bit stays set.
- R9: `irq_stat` equals `irq_raw & irq_mask`, where a mask bit of 1 lets its source through. `irq_line` is the OR of all bits of `irq_stat`.
- R10: While `enable` is low, both queues are emptied on the next clock edge. Writes and pushes made while `enable` is low are ignored.
- R11: A push and a pop on the same queue in one cycle leave its level unchanged when the queue is neither empty nor full, and the words still leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; low empties both queues |
| wr_valid | input | 1 | Register write into the transmit queue |
| wr_data | input | DATA_W | Word to write, right-justified |
| tx_pop | input | 1 | Shifter takes the transmit head word |
| tx_data | output | DATA_W | Transmit head word |
| tx_empty | output | 1 | Transmit queue holds no word |
| rx_push | input | 1 | Shifter stores a received word |
| rx_word | input | DATA_W | Received word, right-justified |
| rd_req | input | 1 | Register read of the receive queue |
| rd_data | output | DATA_W | Receive head word, valid when `rx_level` is not 0 |
| tx_level | output | CNT_W | Transmit fill count, 0 to DEPTH |
| rx_level | output | CNT_W | Receive fill count, 0 to DEPTH |
| tx_thresh | input | THR_W | Transmit low-level setting |
| rx_thresh | input | THR_W | Receive high-level setting |
| irq_mask | input | 5 | Per-source enable, 1 = pass |
| err_clr | input | 1 | Clears the three sticky error flags |
| irq_raw | output | 5 | Unmasked sources: 0 tx low, 1 tx overflow, 2 rx overrun, 3 rx underflow, 4 rx high |
| irq_stat | output | 5 | Masked sources |
| irq_line | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: 16-bit words, 256 entries and a registered-free combined line. This lets it drive both queues all the way to a level of 256, which exercises the ninth count bit, the pointer wrap and the full-queue error paths. The 8-bit threshold ports are swept across the edges where each comparison flips: level 3 against 4 on the transmit side, and levels 1 and 2 on the receive side, where the plus-one offset matters. The error cases are driven in combination with the clear strobe and the enable input.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
   localparam int IRQ_N       = 5;
   localparam int IRQ_TX_LOW  = 0;
   localparam int IRQ_TX_OVF  = 1;
   localparam int IRQ_RX_OVR  = 2;
   localparam int IRQ_RX_UNF  = 3;
   localparam int IRQ_RX_HIGH = 4;
   localparam int ERR_N       = 3;

   // sticky error events in the order they occupy irq_raw[3:1]
   typedef struct packed {
      logic rx_unf;
      logic rx_ovr;
      logic tx_ovf;
   } err_evt_t;
endpackage

// File: rtl/sfq_queue.sv
module sfq_queue #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  level,
   output logic              push_lost,
   output logic              pop_lost
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sfq_queue: DEPTH must be at least 2");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("sfq_queue: DEPTH must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sfq_queue: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic              full, empty, do_push, do_pop;

   assign full    = (level == CNT_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign push_lost = push && full;
   assign pop_lost  = pop && empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         unique case ({do_push, do_pop})
            2'b10:   level <= level + CNT_W'(1);
            2'b01:   level <= level - CNT_W'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sfq_irq.sv
module sfq_irq
   import sfq_pkg::*;
#(
   parameter int CNT_W   = 9,
   parameter bit REG_OUT = 1'b0,
   localparam int THR_W  = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_level,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [THR_W-1:0] tx_thr,
   input  logic [THR_W-1:0] rx_thr,
   input  err_evt_t         evt,
   input  logic             err_clr,
   input  logic [IRQ_N-1:0] mask,
   output logic [IRQ_N-1:0] raw,
   output logic [IRQ_N-1:0] stat,
   output logic             line
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("sfq_irq: CNT_W must be at least 2");
   end

   logic [ERR_N-1:0] evt_v, sticky;
   logic             tx_low, rx_high;
   logic [CNT_W-1:0] rx_lim;

   assign evt_v = evt;

   for (genvar i = 0; i < ERR_N; i++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)        sticky[i] <= 1'b0;
         else if (evt_v[i]) sticky[i] <= 1'b1;
         else if (err_clr)  sticky[i] <= 1'b0;
      end
   end

   assign rx_lim  = {1'b0, rx_thr} + CNT_W'(1);
   assign tx_low  = (tx_level <= {1'b0, tx_thr});
   assign rx_high = (rx_level >= rx_lim);

   always_comb begin
      raw              = '0;
      raw[IRQ_TX_LOW]  = tx_low;
      raw[IRQ_TX_OVF]  = sticky[0];
      raw[IRQ_RX_OVR]  = sticky[1];
      raw[IRQ_RX_UNF]  = sticky[2];
      raw[IRQ_RX_HIGH] = rx_high;
   end

   assign stat = raw & mask;

   if (REG_OUT) begin : g_line_reg
      always_ff @(posedge clk) begin
         if (!rst_n) line <= 1'b0;
         else        line <= |stat;
      end
   end else begin : g_line_comb
      assign line = |stat;
   end
endmodule

// File: rtl/spi_fifo_irq_core.sv
module spi_fifo_irq_core
   import sfq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 256,
   parameter bit REG_LINE = 1'b0,
   localparam int CNT_W   = $clog2(DEPTH) + 1,
   localparam int THR_W   = CNT_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_empty,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  tx_level,
   output logic [CNT_W-1:0]  rx_level,
   input  logic [THR_W-1:0]  tx_thresh,
   input  logic [THR_W-1:0]  rx_thresh,
   input  logic [IRQ_N-1:0]  irq_mask,
   input  logic              err_clr,
   output logic [IRQ_N-1:0]  irq_raw,
   output logic [IRQ_N-1:0]  irq_stat,
   output logic              irq_line
);
   logic     clr;
   logic     tx_ovf_evt, tx_pop_unused, rx_ovr_evt, rx_unf_evt;
   err_evt_t evt;

   assign clr = !enable;

   sfq_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (wr_valid && enable),
      .push_data (wr_data),
      .pop       (tx_pop && enable),
      .head      (tx_data),
      .level     (tx_level),
      .push_lost (tx_ovf_evt),
      .pop_lost  (tx_pop_unused)
   );

   sfq_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (rx_push && enable),
      .push_data (rx_word),
      .pop       (rd_req && enable),
      .head      (rd_data),
      .level     (rx_level),
      .push_lost (rx_ovr_evt),
      .pop_lost  (rx_unf_evt)
   );

   assign tx_empty = (tx_level == '0);

   always_comb begin
      evt.tx_ovf = tx_ovf_evt;
      evt.rx_ovr = rx_ovr_evt;
      evt.rx_unf = rx_unf_evt;
   end

   sfq_irq #(.CNT_W(CNT_W), .REG_OUT(REG_LINE)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_thr   (tx_thresh),
      .rx_thr   (rx_thresh),
      .evt      (evt),
      .err_clr  (err_clr),
      .mask     (irq_mask),
      .raw      (irq_raw),
      .stat     (irq_stat),
      .line     (irq_line)
   );
endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
   parameter int DEPTH  = 256,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             wr_valid,
   input logic             tx_pop,
   input logic             rx_push,
   input logic             rd_req,
   input logic             err_clr,
   input logic [CNT_W-1:0] tx_level,
   input logic [CNT_W-1:0] rx_level,
   input logic [4:0]       irq_raw
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= FULL && rx_level <= FULL);

   // R5
   tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable && wr_valid && !tx_pop && tx_level == FULL |=> tx_level == FULL && irq_raw[1]);

   // R6
   rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable && rx_push && !rd_req && rx_level == FULL |=> rx_level == FULL && irq_raw[2]);

   // R7
   rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable && rd_req && !rx_push && rx_level == '0 |=> rx_level == '0 && irq_raw[3]);

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_raw[1] && !err_clr |=> irq_raw[1]);

   // R10
   disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> tx_level == '0 && rx_level == '0);

   // R11
   both_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable && rx_push && rd_req && rx_level != '0 && rx_level != FULL |=> $stable(rx_level));
endmodule

bind spi_fifo_irq_core sfq_chk #(.DEPTH(DEPTH)) u_sfq_chk (.*);

// File: tb/test_spi_fifo_irq_core.sv
module test_spi_fifo_irq_core;
   localparam int DW = 16;
   localparam int DEPTH = 256;
   localparam int CW = 9;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic tx_pop = 1'b0;
   logic [DW-1:0] tx_data;
   logic tx_empty;
   logic rx_push = 1'b0;
   logic [DW-1:0] rx_word = '0;
   logic rd_req = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] tx_level, rx_level;
   logic [TW-1:0] tx_thresh = '0, rx_thresh = '0;
   logic [4:0] irq_mask = '0;
   logic err_clr = 1'b0;
   logic [4:0] irq_raw, irq_stat;
   logic irq_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_fifo_irq_core i_spi_fifo_irq_core (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [DW-1:0] d);
      wr_valid = 1'b1; wr_data = d; tick(); wr_valid = 1'b0;
   endtask

   task automatic rpush(input logic [DW-1:0] d);
      rx_push = 1'b1; rx_word = d; tick(); rx_push = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; enable = 1'b0;
      tick(); tick();
      rst_n = 1'b1; enable = 1'b1;
      tick();
      chk(tx_level == 0, "R1 tx_level", int'(tx_level), 0);
      chk(rx_level == 0, "R1 rx_level", int'(rx_level), 0);
      chk(irq_raw == 5'b00001, "R1 irq_raw", int'(irq_raw), 1);
   endtask

   task automatic t_tx();
      tx_thresh = 8'd3;
      for (int i = 0; i < 3; i++) wr(DW'(16'h1000 + i));
      chk(irq_raw[0] == 1'b1, "R3 tx low at level 3", int'(irq_raw[0]), 1);
      wr(16'h1003);
      chk(irq_raw[0] == 1'b0, "R3 tx low at level 4", int'(irq_raw[0]), 0);
      for (int i = 4; i < DEPTH; i++) wr(DW'(16'h1000 + i));
      chk(tx_level == 9'd256, "R2 tx full level", int'(tx_level), 256);
      chk(irq_raw[1] == 1'b0, "R5 no overflow yet", int'(irq_raw[1]), 0);
      wr(16'hDEAD);
      chk(tx_level == 9'd256, "R5 level after dropped write", int'(tx_level), 256);
      chk(irq_raw[1] == 1'b1, "R5 overflow flag", int'(irq_raw[1]), 1);
      begin
         int bad = 0;
         for (int i = 0; i < DEPTH; i++) begin
            if (tx_data != DW'(16'h1000 + i)) begin
               if (bad == 0) chk(1'b0, "R2 tx order", int'(tx_data), 16'h1000 + i);
               bad++;
            end
            tx_pop = 1'b1; tick(); tx_pop = 1'b0;
         end
         chk(bad == 0, "R5 contents unchanged", bad, 0);
      end
      chk(tx_empty == 1'b1 && tx_level == 0, "R2 tx empty", int'(tx_level), 0);
      tx_pop = 1'b1; tick(); tx_pop = 1'b0;
      chk(tx_level == 0, "R2 pop on empty ignored", int'(tx_level), 0);
   endtask

   task automatic t_rx();
      rx_thresh = 8'd1;
      rpush(16'h2000);
      chk(irq_raw[4] == 1'b0, "R4 rx high at level 1", int'(irq_raw[4]), 0);
      rpush(16'h2001);
      chk(irq_raw[4] == 1'b1, "R4 rx high at level 2", int'(irq_raw[4]), 1);
      for (int i = 2; i < DEPTH; i++) rpush(DW'(16'h2000 + i));
      rpush(16'hBEEF);
      chk(rx_level == 9'd256, "R6 level after overrun", int'(rx_level), 256);
      chk(irq_raw[2] == 1'b1, "R6 overrun flag", int'(irq_raw[2]), 1);
      begin
         int bad = 0;
         for (int i = 0; i < DEPTH; i++) begin
            if (rd_data != DW'(16'h2000 + i)) bad++;
            rd_req = 1'b1; tick(); rd_req = 1'b0;
         end
         chk(bad == 0, "R6 discarded word absent", bad, 0);
      end
      chk(irq_raw[3] == 1'b0, "R7 no underflow yet", int'(irq_raw[3]), 0);
      rd_req = 1'b1; tick(); rd_req = 1'b0;
      chk(rx_level == 0, "R7 level stays 0", int'(rx_level), 0);
      chk(irq_raw[3] == 1'b1, "R7 underflow flag", int'(irq_raw[3]), 1);
   endtask

   task automatic t_clear();
      repeat (5) tick();
      chk(irq_raw[3:1] == 3'b111, "R8 flags held", int'(irq_raw[3:1]), 7);
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk(irq_raw[3:1] == 3'b000, "R8 flags cleared", int'(irq_raw[3:1]), 0);
      wr(16'h0001);
      tx_pop = 1'b1; tick(); tx_pop = 1'b0;
      for (int i = 0; i < DEPTH; i++) wr(DW'(i));
      wr(16'h7777);
      rd_req = 1'b1; err_clr = 1'b1; tick(); rd_req = 1'b0; err_clr = 1'b0;
      chk(irq_raw[3:1] == 3'b100, "R8 set wins over clear", int'(irq_raw[3:1]), 4);
   endtask

   task automatic t_enable();
      for (int i = 0; i < 5; i++) rpush(DW'(i));
      chk(tx_level == 9'd256 && rx_level == 9'd5, "R10 levels before disable",
          int'(rx_level), 5);
      enable = 1'b0; tick();
      chk(tx_level == 0 && rx_level == 0, "R10 flushed", int'(tx_level) + int'(rx_level), 0);
      wr(16'h1111); rpush(16'h2222);
      chk(tx_level == 0 && rx_level == 0, "R10 pushes ignored while off",
          int'(tx_level) + int'(rx_level), 0);
      enable = 1'b1; tick();
      err_clr = 1'b1; tick(); err_clr = 1'b0;
      chk(irq_raw == 5'b00001, "R10 clean after re-enable", int'(irq_raw), 1);
   endtask

   task automatic t_mask();
      rd_req = 1'b1; tick(); rd_req = 1'b0;
      // raw is now tx low (bit0) and rx underflow (bit3)
      irq_mask = 5'b00001; #1;
      chk(irq_stat == 5'b00001 && irq_line, "R9 mask bit0", int'(irq_stat), 1);
      irq_mask = 5'b10110; #1;
      chk(irq_stat == 5'b00000 && !irq_line, "R9 masked off", int'(irq_stat), 0);
      irq_mask = 5'b01000; #1;
      chk(irq_stat == 5'b01000 && irq_line, "R9 mask bit3", int'(irq_stat), 8);
      irq_mask = 5'b00000;
      err_clr = 1'b1; tick(); err_clr = 1'b0;
   endtask

   task automatic t_both();
      for (int i = 0; i < 3; i++) rpush(DW'(16'h3000 + i));
      begin
         int bad = 0;
         for (int i = 0; i < 4; i++) begin
            if (rd_data != DW'(16'h3000 + i)) bad++;
            rx_push = 1'b1; rx_word = DW'(16'h3003 + i); rd_req = 1'b1;
            tick();
            rx_push = 1'b0; rd_req = 1'b0;
            if (rx_level != 9'd3) bad++;
         end
         chk(bad == 0, "R11 rx level steady", bad, 0);
         bad = 0;
         for (int i = 4; i < 7; i++) begin
            if (rd_data != DW'(16'h3000 + i)) bad++;
            rd_req = 1'b1; tick(); rd_req = 1'b0;
         end
         chk(bad == 0 && rx_level == 0, "R11 rx order kept", bad, 0);
      end
      wr(16'h4000);
      wr_valid = 1'b1; wr_data = 16'h4001; tx_pop = 1'b1; tick();
      wr_valid = 1'b0; tx_pop = 1'b0;
      chk(tx_level == 9'd1 && tx_data == 16'h4001, "R11 tx push and pop",
          int'(tx_data), 16'h4001);
   endtask

   initial begin
      t_reset();
      t_tx();
      t_rx();
      t_clear();
      t_enable();
      t_mask();
      t_both();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule